// File: doc/BRIEF.md
# Shifter with Carry and Extend

This block shifts a data word by a count supplied from a register. It supports three kinds of shift: logical left, logical right and arithmetic right. Each operation also produces a carry-out bit and an extend bit. Together these give the shift class of a condition-flag generator what it needs. The count is reduced modulo twice the word width. Counts of zero, counts equal to the word width and counts beyond it each follow a fixed rule, so the flags never depend on how the shifter is built.

A caller presents the operands with a one-cycle strobe. The result and flags appear on the registered outputs one clock later and stay there until the next strobe. When the count is zero, or the reserved kind code is used, the previous carry is kept. This lets a zero-count shift leave the flag state untouched.

Top module: `shift_carry_unit`

## Requirements
- R1: The effective count is the count input modulo 2*WIDTH (64 by default); bits of the count input above bit 5 have no effect on any output.
- R2: With an effective count of zero, the result equals the input data, and carry and extend keep their values from the previous operation.
- R3: Kind code 0 (logical left) with count c in 1..31 gives data shifted left by c, with carry equal to input bit (32 - c).
- R4: A logical shift (kind 0 or 1) by a count of 33..63 gives a zero result with carry cleared.
- R5: Kind code 0 with a count of exactly 32 gives a zero result with carry equal to input bit 0.
- R6: Kind code 1 (logical right) with count c in 1..31 gives zero-filled data shifted right by c, with carry equal to input bit (c - 1). A count of exactly 32 gives zero, with carry equal to input bit 31.
- R7: Kind code 2 (arithmetic right) with count c in 1..31 fills the vacated bits with input bit 31, with carry equal to input bit (c - 1).
- R8: Kind code 2 with a count of 32..63 gives every result bit equal to input bit 31, with carry equal to input bit 31.
- R9: The extend output always equals the carry output.
- R10: Kind code 3 is reserved: the result equals the input data and carry and extend keep their previous values, whatever the count.
- R11: The outputs update only on the clock edge that samples in_valid high. out_valid is high in exactly the cycle after a strobe. Without a strobe, data, carry and extend hold.
- R12: After reset, out_valid, out_data, out_carry and out_extend are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_kind | input | 2 | Shift kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 reserved |
| in_data | input | WIDTH (32) | Word to shift |
| in_count | input | CNT_IN_W (8) | Shift count, reduced modulo 2*WIDTH |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | WIDTH (32) | Shifted word |
| out_carry | output | 1 | Last bit shifted out, or kept carry |
| out_extend | output | 1 | Extend flag, copy of the carry |

## Verification
The assertions check four things on every cycle: the extend-equals-carry rule, the one-cycle strobe latency, the holding of outputs between strobes, and the three count regimes that have closed forms. Those regimes are zero-count carry retention, the zero result with cleared carry of an over-long logical shift, and the sign fill of a long arithmetic shift. The exact bit that becomes the carry for counts 1 to 32, and the shifted data itself, are shown only by the bench. It sweeps every count for each kind over several data patterns and compares against an arithmetic model built on wide vectors. The bench also shows that the high count bits and the reserved kind are ignored, since that needs the previous carry in both states.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SK_LSL  = 2'd0,
    SK_LSR  = 2'd1,
    SK_ASR  = 2'd2,
    SK_RSVD = 2'd3
  } shf_kind_e;

  localparam int unsigned SHF_DEF_WIDTH = 32;

endpackage

// File: rtl/shf_count_reduce.sv
module shf_count_reduce #(
  parameter int unsigned CNT_IN_W = 8,
  parameter int unsigned CNT_W    = 6
) (
  input  logic [CNT_IN_W-1:0] cnt_in,
  output logic [CNT_W-1:0]    cnt_eff,
  output logic                cnt_zero
);

  logic unused_cnt_hi;

  generate
    if (CNT_IN_W > CNT_W) begin : g_trim
      assign cnt_eff       = cnt_in[CNT_W-1:0];
      assign unused_cnt_hi = ^cnt_in[CNT_IN_W-1:CNT_W];
    end else begin : g_pass
      assign cnt_eff       = CNT_W'(cnt_in);
      assign unused_cnt_hi = 1'b0;
    end
  endgenerate

  assign cnt_zero = (cnt_eff == '0);

endmodule

// File: rtl/shf_lane.sv
module shf_lane
  import shf_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CNT_W = 6,
  parameter shf_kind_e   KIND  = SK_LSL
) (
  input  logic [WIDTH-1:0] x,
  input  logic [CNT_W-1:0] c,
  output logic [WIDTH-1:0] res,
  output logic             cy
);

  localparam logic [CNT_W-1:0] W_CNT = CNT_W'(WIDTH);

  // Left logical: shift by c-1, take the top bit as carry, then one more.
  function automatic logic [WIDTH:0] f_lsl(input logic [WIDTH-1:0] v,
                                           input logic [CNT_W-1:0] n);
    logic [WIDTH-1:0] pre;
    if (n > W_CNT) return '0;
    pre = v << (n - 1'b1);
    return {pre[WIDTH-1], pre << 1};
  endfunction

  // Right logical: shift by c-1, carry is the bottom bit.
  function automatic logic [WIDTH:0] f_lsr(input logic [WIDTH-1:0] v,
                                           input logic [CNT_W-1:0] n);
    logic [WIDTH-1:0] pre;
    if (n > W_CNT) return '0;
    pre = v >> (n - 1'b1);
    return {pre[0], pre >> 1};
  endfunction

  // Right arithmetic: counts at or past the width saturate to the width.
  function automatic logic [WIDTH:0] f_asr(input logic [WIDTH-1:0] v,
                                           input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] sat;
    logic [WIDTH-1:0] pre;
    logic [WIDTH-1:0] fin;
    sat = (n > W_CNT) ? W_CNT : n;
    pre = WIDTH'($signed(v) >>> (sat - 1'b1));
    fin = WIDTH'($signed(pre) >>> 1);
    return {pre[0], fin};
  endfunction

  logic [WIDTH:0] packed_out;

  generate
    if (KIND == SK_LSL) begin : g_lsl
      assign packed_out = f_lsl(x, c);
    end else if (KIND == SK_LSR) begin : g_lsr
      assign packed_out = f_lsr(x, c);
    end else begin : g_asr
      assign packed_out = f_asr(x, c);
    end
  endgenerate

  assign res = packed_out[WIDTH-1:0];
  assign cy  = packed_out[WIDTH];

endmodule

// File: rtl/shf_out_reg.sv
module shf_out_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             keep_carry,
  input  logic [WIDTH-1:0] nxt_data,
  input  logic             nxt_carry,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_data,
  output logic             q_carry,
  output logic             q_extend
);

  logic carry_sel;

  assign carry_sel = keep_carry ? q_carry : nxt_carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_data   <= '0;
      q_carry  <= 1'b0;
      q_extend <= 1'b0;
    end else begin
      q_valid <= take;
      if (take) begin
        q_data   <= nxt_data;
        q_carry  <= carry_sel;
        q_extend <= carry_sel;
      end
    end
  end

endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shf_pkg::*;
#(
  parameter int unsigned WIDTH    = SHF_DEF_WIDTH,
  parameter int unsigned CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_kind,
  input  logic [WIDTH-1:0]    in_data,
  input  logic [CNT_IN_W-1:0] in_count,
  output logic                out_valid,
  output logic [WIDTH-1:0]    out_data,
  output logic                out_carry,
  output logic                out_extend
);

  localparam int unsigned CNT_W   = $clog2(WIDTH) + 1;
  localparam int unsigned N_LANES = 3;

  logic [CNT_W-1:0] eff_cnt;
  logic             cnt_zero;
  logic             kind_rsvd;
  logic             keep_carry;
  logic [WIDTH-1:0] lane_res [N_LANES];
  logic             lane_cy  [N_LANES];
  logic [WIDTH-1:0] sel_res;
  logic             sel_cy;

  shf_count_reduce #(.CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W)) u_cnt (
    .cnt_in   (in_count),
    .cnt_eff  (eff_cnt),
    .cnt_zero (cnt_zero)
  );

  generate
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      shf_lane #(.WIDTH(WIDTH), .CNT_W(CNT_W), .KIND(shf_kind_e'(k))) u_lane (
        .x   (in_data),
        .c   (eff_cnt),
        .res (lane_res[k]),
        .cy  (lane_cy[k])
      );
    end
  endgenerate

  assign kind_rsvd  = (shf_kind_e'(in_kind) == SK_RSVD);
  assign keep_carry = cnt_zero || kind_rsvd;

  always_comb begin
    sel_res = lane_res[0];
    sel_cy  = lane_cy[0];
    unique case (shf_kind_e'(in_kind))
      SK_LSL:  begin sel_res = lane_res[0]; sel_cy = lane_cy[0]; end
      SK_LSR:  begin sel_res = lane_res[1]; sel_cy = lane_cy[1]; end
      SK_ASR:  begin sel_res = lane_res[2]; sel_cy = lane_cy[2]; end
      default: begin sel_res = in_data;     sel_cy = 1'b0;       end
    endcase
    if (cnt_zero) sel_res = in_data;
  end

  shf_out_reg #(.WIDTH(WIDTH)) u_oreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (in_valid),
    .keep_carry (keep_carry),
    .nxt_data   (sel_res),
    .nxt_carry  (sel_cy),
    .q_valid    (out_valid),
    .q_data     (out_data),
    .q_carry    (out_carry),
    .q_extend   (out_extend)
  );

endmodule

// File: rtl/shift_carry_unit_chk.sv
module shift_carry_unit_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_kind,
  input logic [WIDTH-1:0] in_data,
  input logic [CNT_W-1:0] eff_cnt,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic             out_carry,
  input logic             out_extend
);

  localparam logic [CNT_W-1:0] W_CNT = CNT_W'(WIDTH);

  logic is_logical;
  logic is_asr;
  assign is_logical = (in_kind == 2'd0) || (in_kind == 2'd1);
  assign is_asr     = (in_kind == 2'd2);

  AST_EXTEND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_extend == out_carry); // R9

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_carry))); // R11

  AST_ZERO_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_cnt == '0) |=>
      (out_carry == $past(out_carry) && out_data == $past(in_data))); // R2

  AST_LOGICAL_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_logical && eff_cnt > W_CNT) |=>
      (out_data == '0 && !out_carry)); // R4

  AST_ASR_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_asr && eff_cnt >= W_CNT) |=>
      (out_data == {WIDTH{$past(in_data[WIDTH-1])}} &&
       out_carry == $past(in_data[WIDTH-1]))); // R8

  AST_RSVD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd3) |=>
      (out_carry == $past(out_carry) && out_data == $past(in_data))); // R10

endmodule

bind shift_carry_unit shift_carry_unit_chk #(
  .WIDTH (WIDTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_kind    (in_kind),
  .in_data    (in_data),
  .eff_cnt    (eff_cnt),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_carry  (out_carry),
  .out_extend (out_extend)
);

// File: tb/shift_carry_unit_tb_top.sv
module shift_carry_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int CIW        = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [1:0]     in_kind = 2'd0;
  logic [W-1:0]   in_data = '0;
  logic [CIW-1:0] in_count = '0;
  logic           out_valid;
  logic [W-1:0]   out_data;
  logic           out_carry;
  logic           out_extend;

  int n_checks = 0;
  int n_errors = 0;
  logic model_cy = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_carry_unit #(.WIDTH(W), .CNT_IN_W(CIW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .in_data    (in_data),
    .in_count   (in_count),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_carry  (out_carry),
    .out_extend (out_extend)
  );

  // Model: wide vectors, bits that fall past the window are simply lost.
  function automatic logic [W:0] model(input logic [1:0] k, input logic [W-1:0] x,
                                       input int c, input logic prev);
    logic [2*W:0]          vl;
    logic [2*W-1:0]        vr;
    logic signed [3*W-1:0] va;
    if (k == 2'd3 || c == 0) return {prev, x};
    case (k)
      2'd0: begin vl = {{(W+1){1'b0}}, x} << c; return {vl[W], vl[W-1:0]}; end
      2'd1: begin vr = {x, {W{1'b0}}} >> c;     return {vr[W-1], vr[2*W-1:W]}; end
      default: begin
        va = $signed({{W{x[W-1]}}, x, {W{1'b0}}}) >>> c;
        return {va[W-1], va[2*W-1:W]};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] k, input int c, input bit hi);
    if (hi) return "R1";
    if (k == 2'd3) return "R10";
    if (c == 0) return "R2";
    if (k == 2'd0) return (c < 32) ? "R3" : (c == 32) ? "R5" : "R4";
    if (k == 2'd1) return (c <= 32) ? "R6" : "R4";
    return (c < 32) ? "R7" : "R8";
  endfunction

  task automatic check(input string req, input bit ok, input logic [W+2:0] act,
                       input logic [W+2:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [W-1:0] x, input int c,
                       input logic [CIW-1:0] hi_bits);
    logic [W:0] e;
    logic [CIW-1:0] cnt;
    cnt = CIW'(c) | hi_bits;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_data = x; in_count = cnt;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(k, x, c, model_cy);
    check(req_of(k, c, hi_bits != 0),
          out_valid && out_data == e[W-1:0] && out_carry == e[W],
          {out_valid, out_extend, out_carry, out_data}, {1'b1, e[W], e[W], e[W-1:0]});
    check("R9", out_extend == out_carry, {2'b0, out_extend, W'(0)}, {2'b0, out_carry, W'(0)});
    model_cy = e[W];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_96F0;
    pats[3] = 32'h1234_5679;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", !out_valid && out_data == '0 && !out_carry && !out_extend,
          {out_valid, out_extend, out_carry, out_data}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", !out_valid, {2'b0, out_valid, W'(0)}, '0);

    // Full sweep of kinds, counts and patterns; upper count bits toggled (R1).
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) begin
        for (int c = 0; c < 64; c++) begin
          apply(2'(k), pats[p], c, (p[0] ^ c[0]) ? 8'hC0 : 8'h00);
        end
      end
    end

    // R2: zero count keeps a carry of 1 and of 0
    apply(2'd0, 32'h8000_0000, 1, 8'h00);   // carry becomes 1
    apply(2'd1, 32'h0000_0000, 0, 8'h40);   // keep 1
    apply(2'd1, 32'h0000_0002, 1, 8'h00);   // carry becomes 0
    apply(2'd2, 32'hFFFF_FFFF, 0, 8'h00);   // keep 0

    // R10: reserved kind with various counts, carry in both states
    apply(2'd2, 32'hFFFF_FFFF, 5, 8'h00);   // carry 1
    for (int c = 0; c < 64; c += 9) apply(2'd3, 32'hDEAD_BEEF ^ 32'(c), c, 8'h00);
    apply(2'd1, 32'h0000_0000, 40, 8'h00);  // carry 0
    for (int c = 1; c < 64; c += 13) apply(2'd3, 32'h0F0F_0F0F, c, 8'h80);

    // R11: outputs hold while no strobe, whatever the inputs do
    apply(2'd0, 32'h0000_00FF, 4, 8'h00);
    for (int i = 0; i < 4; i++) begin
      in_kind = 2'(i); in_data = 32'h5555_0000 + 32'(i); in_count = 8'(i + 1);
      @(negedge clk);
      check("R11", !out_valid && out_data == 32'h0000_0FF0 && !out_carry,
            {out_valid, out_extend, out_carry, out_data}, {3'b000, 32'h0000_0FF0});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule